// File: doc/BRIEF.md
# Address-Swapping Reply Frame Transmitter

This block builds a reply frame and sends it out one byte per cycle on a byte-wide streaming source interface. The interface has a ready signal, start-of-frame and end-of-frame markers, all active low. A client loads the payload as 32-bit words through a four-phase request/acknowledge handshake. Each word carries a two-bit framing tag. A start tag rewinds the buffer pointer. An end tag fixes the frame length and launches transmission.

The reply always goes back to whoever sent the last received frame. The twelve address bytes at the front of the outgoing frame are read from the stored receive buffer with the two six-byte addresses exchanged. Everything from byte 12 onward comes from the block's own transmit buffer. The receive buffer is outside the block. The block reads it through an address output and a data input with a combinational response.

Top module: `fxt_reply_tx`

## Requirements
- R1: A word is stored as four bytes at consecutive buffer indices, most significant byte at the lowest index.
- R2: Tag bit 0 (start) sets the write pointer to zero before the word is stored. Tag bit 1 (end) sets the frame length to the pointer value after the word. Both bits may be set together. After an end write, the frame is presented (tx_src_rdy_n low, tx_sof_n low) one cycle after wr_ack rises.
- R3: Frame bytes 0 to 5 are receive-buffer bytes 6 to 11, and frame bytes 6 to 11 are receive-buffer bytes 0 to 5.
- R4: Frame bytes 12 up to length minus one are the transmit-buffer bytes at the same indices. Transmit-buffer bytes 0 to 11 never appear on tx_data.
- R5: When the latched length is less than 12, the frame consists of the 12 address bytes only, and the end marker sits on byte 11.
- R6: tx_sof_n is low only while byte 0 is presented, and tx_eof_n is low only while the last byte is presented.
- R7: tx_src_rdy_n stays low from the first byte until the last byte is transferred, and it is high in the cycle after that transfer.
- R8: A byte is transferred only at a clock edge where both tx_src_rdy_n and tx_dst_rdy_n are low. While tx_dst_rdy_n is high, tx_data, tx_sof_n and tx_eof_n hold their values.
- R9: wr_ack rises in the cycle after a request is accepted, and it falls in the cycle after wr_req is seen low. A new write is accepted only once wr_ack is low again.
- R10: No write is accepted, and wr_ack stays low, while a frame is being transmitted.
- R11: After reset, tx_src_rdy_n, tx_sof_n and tx_eof_n are high and wr_ack is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_req | input | 1 | Word write request (four-phase) |
| wr_data | input | WORD_W | Word to store, big-endian |
| wr_tag | input | 2 | Framing tag: bit 0 start, bit 1 end |
| wr_ack | output | 1 | Word write acknowledge |
| rx_rd_addr | output | AW | Receive-buffer byte address |
| rx_rd_data | input | 8 | Receive-buffer byte at rx_rd_addr, same cycle |
| tx_data | output | 8 | Frame byte |
| tx_sof_n | output | 1 | Start of frame, active low |
| tx_eof_n | output | 1 | End of frame, active low |
| tx_src_rdy_n | output | 1 | Byte valid, active low |
| tx_dst_rdy_n | input | 1 | Sink ready, active low |

## Verification
The acknowledge is due one cycle after a request, and it clears one cycle after the request is dropped. After an end-tagged write, the first byte is due one cycle after the acknowledge, because it passes through the writer's start register and then the emitter's busy flag. The bench drives inputs on falling edges and samples just after them, so each check falls on the first falling edge at which the result can be present. When the sink is ready, a presented byte moves on the next rising edge. Every byte is checked at the falling edge before that rising edge, and the ready flag is checked at the falling edge after the last transfer.

// File: rtl/fxt_pkg.sv
package fxt_pkg;
   localparam int MAC_BYTES = 6;
   localparam int HDR_BYTES = 2 * MAC_BYTES;
   localparam int TAG_START = 0;
   localparam int TAG_END   = 1;

   typedef enum logic {
      WS_IDLE,
      WS_ACK
   } wr_state_e;
endpackage

// File: rtl/fxt_word_writer.sv
module fxt_word_writer
   import fxt_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int AW     = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_req,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [1:0]        wr_tag,
   input  logic              busy,
   output logic              wr_ack,
   output logic              mem_we,
   output logic [AW-1:0]     mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   output logic              start,
   output logic [AW:0]       frame_len
);
   localparam int NB = WORD_W / 8;

   wr_state_e   state;
   logic [AW:0] ptr;
   logic [AW:0] base;
   logic [AW:0] next_ptr;
   logic        accept;

   always_comb begin
      accept    = (state == WS_IDLE) && wr_req && !busy;
      base      = wr_tag[TAG_START] ? '0 : ptr;
      next_ptr  = base + (AW+1)'(NB);
      mem_we    = accept;
      mem_addr  = base[AW-1:0];
      mem_wdata = wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= WS_IDLE;
         wr_ack    <= 1'b0;
         ptr       <= '0;
         frame_len <= '0;
         start     <= 1'b0;
      end else begin
         start <= 1'b0;
         case (state)
            WS_IDLE: if (accept) begin
               ptr    <= next_ptr;
               wr_ack <= 1'b1;
               state  <= WS_ACK;
               if (wr_tag[TAG_END]) begin
                  frame_len <= next_ptr;
                  start     <= 1'b1;
               end
            end
            WS_ACK: if (!wr_req) begin
               wr_ack <= 1'b0;
               state  <= WS_IDLE;
            end
            default: state <= WS_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/fxt_byte_store.sv
module fxt_byte_store #(
   parameter int WORD_W = 32,
   parameter int AW     = 11
) (
   input  logic              clk,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [WORD_W-1:0] wdata,
   input  logic [AW-1:0]     raddr,
   output logic [7:0]        rdata
);
   localparam int NB    = WORD_W / 8;
   localparam int DEPTH = 1 << AW;

   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         for (int k = 0; k < NB; k++) begin
            mem[waddr + AW'(k)] <= wdata[WORD_W-1-8*k -: 8];
         end
      end
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/fxt_emitter.sv
module fxt_emitter
   import fxt_pkg::*;
#(
   parameter int AW = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [AW:0]   frame_len,
   input  logic [7:0]    rx_rd_data,
   input  logic [7:0]    store_rd_data,
   input  logic          dst_rdy_n,
   output logic          busy,
   output logic [AW-1:0] rx_rd_addr,
   output logic [AW-1:0] store_rd_addr,
   output logic [7:0]    tx_data,
   output logic          sof_n,
   output logic          eof_n,
   output logic          src_rdy_n
);
   localparam logic [AW:0] HDR = (AW+1)'(HDR_BYTES);
   localparam logic [AW:0] MAC = (AW+1)'(MAC_BYTES);

   logic [AW:0] idx;
   logic [AW:0] last_idx;
   logic [AW:0] hdr_addr;
   logic        in_hdr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         idx      <= '0;
         last_idx <= '0;
      end else if (start) begin
         busy     <= 1'b1;
         idx      <= '0;
         last_idx <= (frame_len < HDR) ? HDR - 1'b1 : frame_len - 1'b1;
      end else if (busy && !dst_rdy_n) begin
         if (idx == last_idx) busy <= 1'b0;
         else                 idx  <= idx + 1'b1;
      end
   end

   always_comb begin
      in_hdr        = idx < HDR;
      hdr_addr      = (idx < MAC) ? idx + MAC : idx - MAC;
      rx_rd_addr    = hdr_addr[AW-1:0];
      store_rd_addr = idx[AW-1:0];
      tx_data       = in_hdr ? rx_rd_data : store_rd_data;
      src_rdy_n     = !busy;
      sof_n         = !(busy && idx == '0);
      eof_n         = !(busy && idx == last_idx);
   end
endmodule

// File: rtl/fxt_reply_tx.sv
module fxt_reply_tx #(
   parameter int BUF_BYTES = 2048,
   parameter int WORD_W    = 32,
   localparam int AW       = $clog2(BUF_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_req,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [1:0]        wr_tag,
   output logic              wr_ack,
   output logic [AW-1:0]     rx_rd_addr,
   input  logic [7:0]        rx_rd_data,
   output logic [7:0]        tx_data,
   output logic              tx_sof_n,
   output logic              tx_eof_n,
   output logic              tx_src_rdy_n,
   input  logic              tx_dst_rdy_n
);
   if (BUF_BYTES != (1 << AW) || BUF_BYTES < 16) begin : g_bad_depth
      $error("BUF_BYTES must be a power of two of at least 16");
   end
   if (WORD_W % 8 != 0 || WORD_W < 8) begin : g_bad_word
      $error("WORD_W must be a whole number of bytes");
   end

   logic              busy;
   logic              mem_we;
   logic [AW-1:0]     mem_addr;
   logic [WORD_W-1:0] mem_wdata;
   logic              start;
   logic [AW:0]       frame_len;
   logic [AW-1:0]     store_rd_addr;
   logic [7:0]        store_rd_data;

   fxt_word_writer #(.WORD_W(WORD_W), .AW(AW)) i_writer (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_req    (wr_req),
      .wr_data   (wr_data),
      .wr_tag    (wr_tag),
      .busy      (busy),
      .wr_ack    (wr_ack),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .start     (start),
      .frame_len (frame_len)
   );

   fxt_byte_store #(.WORD_W(WORD_W), .AW(AW)) i_store (
      .clk   (clk),
      .we    (mem_we),
      .waddr (mem_addr),
      .wdata (mem_wdata),
      .raddr (store_rd_addr),
      .rdata (store_rd_data)
   );

   fxt_emitter #(.AW(AW)) i_emit (
      .clk           (clk),
      .rst_n         (rst_n),
      .start         (start),
      .frame_len     (frame_len),
      .rx_rd_data    (rx_rd_data),
      .store_rd_data (store_rd_data),
      .dst_rdy_n     (tx_dst_rdy_n),
      .busy          (busy),
      .rx_rd_addr    (rx_rd_addr),
      .store_rd_addr (store_rd_addr),
      .tx_data       (tx_data),
      .sof_n         (tx_sof_n),
      .eof_n         (tx_eof_n),
      .src_rdy_n     (tx_src_rdy_n)
   );
endmodule

// File: rtl/fxt_reply_tx_chk.sv
module fxt_reply_tx_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_req,
   input logic       wr_ack,
   input logic [7:0] tx_data,
   input logic       tx_sof_n,
   input logic       tx_eof_n,
   input logic       tx_src_rdy_n,
   input logic       tx_dst_rdy_n
);
   a_r6_sof_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_sof_n |-> !tx_src_rdy_n);

   a_r6_eof_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_eof_n |-> !tx_src_rdy_n);

   a_r6_frame_opens_with_sof: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_src_rdy_n) |-> !tx_sof_n);

   a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_src_rdy_n && tx_dst_rdy_n) |=>
         (!tx_src_rdy_n && $stable(tx_data) && $stable(tx_sof_n) && $stable(tx_eof_n)));

   a_r7_ready_drops_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_src_rdy_n && !tx_eof_n && !tx_dst_rdy_n) |=> tx_src_rdy_n);

   a_r9_ack_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_ack) |-> $past(wr_req));

   a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ack && !wr_req) |=> !wr_ack);

   a_r10_no_ack_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_ack) |-> $past(tx_src_rdy_n));
endmodule

bind fxt_reply_tx fxt_reply_tx_chk i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .wr_req       (wr_req),
   .wr_ack       (wr_ack),
   .tx_data      (tx_data),
   .tx_sof_n     (tx_sof_n),
   .tx_eof_n     (tx_eof_n),
   .tx_src_rdy_n (tx_src_rdy_n),
   .tx_dst_rdy_n (tx_dst_rdy_n)
);

// File: tb/test_fxt_reply_tx.sv
module test_fxt_reply_tx;
   localparam int CLK_P = 10;
   localparam int AW    = 11;

   // vector: {word count, stall mask, payload seed, expected frame bytes}
   localparam logic [31:0] VEC [5] = '{
      {8'd5, 8'h00, 8'h10, 8'd20},
      {8'd8, 8'h53, 8'h21, 8'd32},
      {8'd4, 8'h00, 8'h7C, 8'd16},
      {8'd3, 8'h0A, 8'hC0, 8'd12},
      {8'd1, 8'h00, 8'hE5, 8'd12}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_req = 1'b0;
   logic [31:0]   wr_data = '0;
   logic [1:0]    wr_tag = '0;
   logic          wr_ack;
   logic [AW-1:0] rx_rd_addr;
   logic [7:0]    rx_rd_data;
   logic [7:0]    tx_data;
   logic          tx_sof_n, tx_eof_n, tx_src_rdy_n;
   logic          tx_dst_rdy_n = 1'b1;
   logic [7:0]    rx_base = 8'h00;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 0;

   always #(CLK_P/2) clk = ~clk;

   assign rx_rd_data = rx_base + 8'(rx_rd_addr);

   fxt_reply_tx i_fxt_reply_tx (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_req       (wr_req),
      .wr_data      (wr_data),
      .wr_tag       (wr_tag),
      .wr_ack       (wr_ack),
      .rx_rd_addr   (rx_rd_addr),
      .rx_rd_data   (rx_rd_data),
      .tx_data      (tx_data),
      .tx_sof_n     (tx_sof_n),
      .tx_eof_n     (tx_eof_n),
      .tx_src_rdy_n (tx_src_rdy_n),
      .tx_dst_rdy_n (tx_dst_rdy_n)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] word_of(input logic [7:0] seed, input int w);
      logic [7:0] b = seed + 8'(4*w);
      return {b, b + 8'd1, b + 8'd2, b + 8'd3};
   endfunction

   function automatic logic [7:0] exp_byte(input int j, input logic [7:0] seed);
      if (j < 6)       return rx_base + 8'(j + 6);
      else if (j < 12) return rx_base + 8'(j - 6);
      else             return seed + 8'(j);
   endfunction

   task automatic write_word(input logic [31:0] d, input logic [1:0] tag);
      int n = 0;
      @(negedge clk);
      wr_req = 1'b1; wr_data = d; wr_tag = tag;
      do begin @(negedge clk); n++; end while (!wr_ack && n < 50);
      check(wr_ack && n == 1, "R9 ack one cycle after req", n, 1);
      wr_req = 1'b0;
      @(negedge clk);
      check(!wr_ack, "R9 ack clears after req drop", wr_ack, 0);
      if (tag[1]) begin
         check(!tx_src_rdy_n && !tx_sof_n, "R2 frame presented after end write",
               {tx_src_rdy_n, tx_sof_n}, 0);
      end
   endtask

   task automatic load_frame(input int nw, input logic [7:0] seed);
      for (int w = 0; w < nw; w++) begin
         write_word(word_of(seed, w), {(w == nw - 1), (w == 0)});
      end
   endtask

   // called at a falling edge; consumes the frame and returns at the falling edge after it
   task automatic collect(input int exp_len, input logic [7:0] mask, input logic [7:0] seed);
      int j = 0;
      int cyc = 0;
      bit held = 0;
      logic [7:0] hd;
      logic hs, he;
      while (j < exp_len && cyc < 1000) begin
         tx_dst_rdy_n = mask[cyc % 8];
         cyc++;
         #1;
         check(!tx_src_rdy_n, "R7 ready low inside frame", tx_src_rdy_n, 0);
         if (held) begin
            check(tx_data == hd && tx_sof_n == hs && tx_eof_n == he, "R8 hold while stalled",
                  {tx_data, tx_sof_n, tx_eof_n}, {hd, hs, he});
         end
         if (!tx_dst_rdy_n) begin
            check(tx_data == exp_byte(j, seed), (j < 12) ? "R3 swapped address byte" : "R1/R4 payload byte",
                  tx_data, exp_byte(j, seed));
            check(tx_sof_n == (j != 0), "R6 sof marker", tx_sof_n, j != 0);
            check(tx_eof_n == (j != exp_len - 1), (exp_len == 12) ? "R5 short frame end" : "R6 eof marker",
                  tx_eof_n, j != exp_len - 1);
            j++;
            held = 0;
         end else begin
            held = 1; hd = tx_data; hs = tx_sof_n; he = tx_eof_n;
         end
         @(negedge clk);
      end
      tx_dst_rdy_n = 1'b1;
      #1;
      check(tx_src_rdy_n, "R7 ready high after last byte", tx_src_rdy_n, 1);
   endtask

   initial begin
      #(CLK_P * 100000);
      check(0, "watchdog", 0, 1);
      done = 1;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(tx_src_rdy_n && tx_sof_n && tx_eof_n && !wr_ack, "R11 reset state",
            {tx_src_rdy_n, tx_sof_n, tx_eof_n, wr_ack}, 4'b1110);
      rst_n = 1'b1;
      @(negedge clk);
      check(tx_src_rdy_n && !wr_ack, "R11 idle after reset", {tx_src_rdy_n, wr_ack}, 2'b10);

      foreach (VEC[i]) begin
         rx_base = VEC[i][15:8] ^ 8'h5A;
         load_frame(int'(VEC[i][31:24]), VEC[i][15:8]);
         collect(int'(VEC[i][7:0]), VEC[i][23:16], VEC[i][15:8]);
      end

      // R10: write held off while a frame waits on the sink
      rx_base = 8'h33;
      load_frame(3, 8'h40);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         check(tx_data == exp_byte(0, 8'h40) && !tx_sof_n, "R8 first byte held",
               tx_data, exp_byte(0, 8'h40));
      end
      wr_req = 1'b1; wr_data = word_of(8'h80, 0); wr_tag = 2'b01;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         check(!wr_ack, "R10 ack withheld during frame", wr_ack, 0);
      end
      collect(12, 8'h00, 8'h40);
      @(negedge clk);
      check(wr_ack, "R10 ack once frame done", wr_ack, 1);
      wr_req = 1'b0;
      @(negedge clk);
      check(!wr_ack, "R9 ack clears", wr_ack, 0);
      for (int w = 1; w < 5; w++) begin
         write_word(word_of(8'h80, w), (w == 4) ? 2'b10 : 2'b00);
      end
      collect(20, 8'h81, 8'h80);

      // R2: start and end on one word gives a 4-byte length, so the frame is header only
      rx_base = 8'h07;
      write_word(word_of(8'h99, 0), 2'b11);
      collect(12, 8'h00, 8'h99);
      done = 1;
   end

   initial begin
      wait (done);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
   end
endmodule